// File: doc/BRIEF.md
# Single-Register Load/Store Address Generator

This block turns one single-register load or store into a memory request and a base-register update. A 5-bit mode field carries five flags:

- pre-index
- add/subtract
- byte/word
- writeback
- load/store

The block combines a 32-bit base value with an offset, according to those flags. The offset is one of two values:

- a zero-extended 12-bit immediate;
- a register operand passed through a barrel shifter, which supports logical left, logical right, arithmetic right and rotate right.

The block produces the request address, the direction, the access size, the byte-lane enables and the store data placed on its lanes. It also raises an unprivileged flag for the post-indexed form that has no writeback bit. The new base value comes with its own write enable.

Requests enter on a valid/ready handshake and leave through one output register stage. A result sits on the outputs one cycle after it is accepted. It stays unchanged while the consumer holds off.

Top module: `ldst_agen`

## Requirements
- R1: The mode field `in_mode` holds pre-index in bit 4, add (up) in bit 3, byte in bit 2, writeback in bit 1 and load in bit 0. Every one of the 32 values is a legal request.
- R2: The offset is the shifted register when `in_use_reg` is 1, and `in_imm` zero-extended when it is 0. With up=1 the combined value is base+offset, with up=0 it is base-offset, both modulo 2^32.
- R3: With pre-index=1, `out_addr` is the combined value. With pre-index=0, `out_addr` is the unmodified base.
- R4: `out_wb_en` is 1 when pre-index=0 or writeback=1, and 0 only when pre-index=1 and writeback=0. When it is 1, `out_wb_value` is the combined value.
- R5: `out_unpriv` is 1 exactly when pre-index=0 and writeback=0.
- R6: `out_byte` equals the byte flag. A byte access sets the single bit `out_lanes[addr[1:0]]`. A word access sets all four lane bits and does no alignment check.
- R7: `out_load` equals the load flag, and a load drives `out_wdata` to zero. A word store drives `in_data` unchanged. A byte store places `in_data[7:0]` at bits [8k+7:8k] with k = addr[1:0], and every other bit is zero.
- R8: `in_shtype` selects the shift: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right, by `in_shamt`. An amount of 0 means no shift for 00. It means a shift by 32 for 01 and 10. For 11 it means a rotate right by one through `in_carry`, which enters bit 31.
- R9: `in_ready` = `out_ready` or not `out_valid`. A request accepted at a clock edge appears on the outputs with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, all outputs stay unchanged. When no request is accepted and `out_ready`=1, `out_valid` drops.
- R10: An active-low asynchronous reset clears `out_valid` and `out_wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 5 | Pre/up/byte/writeback/load flags |
| in_base | input | 32 | Base register value |
| in_data | input | 32 | Store data register value |
| in_use_reg | input | 1 | 1: shifted register offset, 0: immediate |
| in_imm | input | 12 | Immediate displacement |
| in_rm | input | 32 | Register offset before shifting |
| in_shamt | input | 5 | Shift amount |
| in_shtype | input | 2 | Shift kind |
| in_carry | input | 1 | Carry bit used by rotate-by-one |
| out_valid | output | 1 | Request on outputs |
| out_ready | input | 1 | Consumer takes the request |
| out_addr | output | 32 | Memory address |
| out_load | output | 1 | 1: load, 0: store |
| out_byte | output | 1 | 1: byte access, 0: word |
| out_lanes | output | 4 | Byte-lane enables |
| out_wdata | output | 32 | Store data on its lanes |
| out_unpriv | output | 1 | Access with user privilege |
| out_wb_en | output | 1 | Base register writeback enable |
| out_wb_value | output | 32 | New base register value |

## Verification
The hold assertion assumes that the consumer only withdraws `out_ready` while a request is on the outputs. The lane and store-data assertions assume that a valid output came from an accepted request, never from stale payload after reset. The stimulus meets both assumptions: it changes inputs only on the falling clock edge, and it holds `out_ready` low only after a request has reached the outputs. Random mode fields, offsets and shift settings come from a fixed seed. They are mixed with directed sweeps of all 32 mode values, every shift kind at amount zero, all four byte lanes, and a subtraction that wraps below zero.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  // Member order fixes the bit positions: pre is bit 4, load is bit 0.
  typedef struct packed {
    logic pre;
    logic up;
    logic bsel;
    logic wb;
    logic load;
  } mode_t;

endpackage

// File: rtl/lsu_shifter.sv
module lsu_shifter
  import ldst_agen_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  value,
  input  logic [SHW-1:0] amt,
  input  shift_kind_e    kind,
  input  logic           carry_in,
  output logic [DW-1:0]  result
);

  logic            zero_amt;
  logic [2*DW-1:0] doubled;

  always_comb begin
    zero_amt = (amt == '0);
    doubled  = {value, value} >> amt;
    unique case (kind)
      SH_LSL:  result = value << amt;
      SH_LSR:  result = zero_amt ? '0 : (value >> amt);
      SH_ASR:  result = zero_amt ? {DW{value[DW-1]}} : DW'($signed(value) >>> amt);
      default: result = zero_amt ? {carry_in, value[DW-1:1]} : doubled[DW-1:0];
    endcase
  end

endmodule

// File: rtl/lsu_mode_decode.sv
module lsu_mode_decode
  import ldst_agen_pkg::*;
(
  input  logic [4:0] mode_bits,
  output mode_t      flags,
  output logic       wb_en,
  output logic       unpriv
);

  always_comb begin
    flags  = mode_t'(mode_bits);
    wb_en  = !flags.pre || flags.wb;
    unpriv = !flags.pre && !flags.wb;
  end

endmodule

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
  import ldst_agen_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMMW  = 12,
  parameter int LANES = DW / 8,
  parameter int LW    = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    base,
  input  logic [IMMW-1:0]  imm,
  input  logic [DW-1:0]    shifted,
  input  logic             use_reg,
  input  logic [DW-1:0]    data,
  input  mode_t            flags,
  output logic [DW-1:0]    addr,
  output logic [DW-1:0]    wb_value,
  output logic [LANES-1:0] lanes,
  output logic [DW-1:0]    wdata
);

  logic [DW-1:0] offset;
  logic [LW-1:0] lane_idx;

  always_comb begin
    offset   = use_reg ? shifted : {{(DW-IMMW){1'b0}}, imm};
    wb_value = flags.up ? (base + offset) : (base - offset);
    addr     = flags.pre ? wb_value : base;
    lane_idx = addr[LW-1:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lanes[g] = flags.bsel ? (lane_idx == LW'(g)) : 1'b1;
      if (flags.load)
        wdata[g*8 +: 8] = 8'h00;
      else if (flags.bsel)
        wdata[g*8 +: 8] = (lane_idx == LW'(g)) ? data[7:0] : 8'h00;
      else
        wdata[g*8 +: 8] = data[g*8 +: 8];
    end
  end

  // R3: a pre-indexed access addresses the same location it writes back
  a_r3_pre_addr_matches_wb: assert property (@(posedge clk) disable iff (!rst_n)
    flags.pre |-> (addr == wb_value));

  // R6: a byte access enables exactly one lane
  a_r6_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    flags.bsel |-> ($countones(lanes) == 1));

endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_agen_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMMW  = 12,
  parameter int SHW   = $clog2(DW),
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [4:0]       in_mode,
  input  logic [DW-1:0]    in_base,
  input  logic [DW-1:0]    in_data,
  input  logic             in_use_reg,
  input  logic [IMMW-1:0]  in_imm,
  input  logic [DW-1:0]    in_rm,
  input  logic [SHW-1:0]   in_shamt,
  input  logic [1:0]       in_shtype,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_addr,
  output logic             out_load,
  output logic             out_byte,
  output logic [LANES-1:0] out_lanes,
  output logic [DW-1:0]    out_wdata,
  output logic             out_unpriv,
  output logic             out_wb_en,
  output logic [DW-1:0]    out_wb_value
);

  mode_t            flags;
  logic             dec_wb_en;
  logic             dec_unpriv;
  logic [DW-1:0]    shifted;
  logic [DW-1:0]    calc_addr;
  logic [DW-1:0]    calc_wb_value;
  logic [LANES-1:0] calc_lanes;
  logic [DW-1:0]    calc_wdata;

  lsu_mode_decode i_decode (
    .mode_bits (in_mode),
    .flags     (flags),
    .wb_en     (dec_wb_en),
    .unpriv    (dec_unpriv)
  );

  lsu_shifter #(.DW(DW), .SHW(SHW)) i_shifter (
    .value    (in_rm),
    .amt      (in_shamt),
    .kind     (shift_kind_e'(in_shtype)),
    .carry_in (in_carry),
    .result   (shifted)
  );

  lsu_addr_calc #(.DW(DW), .IMMW(IMMW), .LANES(LANES)) i_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (in_base),
    .imm      (in_imm),
    .shifted  (shifted),
    .use_reg  (in_use_reg),
    .data     (in_data),
    .flags    (flags),
    .addr     (calc_addr),
    .wb_value (calc_wb_value),
    .lanes    (calc_lanes),
    .wdata    (calc_wdata)
  );

  // Handshake: next-state logic
  logic accept;
  logic valid_q, valid_d;
  logic wben_q, wben_d;

  always_comb begin
    in_ready = out_ready || !valid_q;
    accept   = in_valid && in_ready;
    if (accept)         valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
    wben_d = accept ? dec_wb_en : wben_q;
  end

  // Control registers carry the reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wben_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wben_q  <= wben_d;
    end
  end

  // Payload registers: clock enable only, no reset
  logic [DW-1:0]    addr_q, wdata_q, wbv_q;
  logic [LANES-1:0] lanes_q;
  logic             load_q, byte_q, unpriv_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q   <= calc_addr;
      wdata_q  <= calc_wdata;
      wbv_q    <= calc_wb_value;
      lanes_q  <= calc_lanes;
      load_q   <= flags.load;
      byte_q   <= flags.bsel;
      unpriv_q <= dec_unpriv;
    end
  end

  assign out_valid    = valid_q;
  assign out_wb_en    = wben_q;
  assign out_addr     = addr_q;
  assign out_wdata    = wdata_q;
  assign out_wb_value = wbv_q;
  assign out_lanes    = lanes_q;
  assign out_load     = load_q;
  assign out_byte     = byte_q;
  assign out_unpriv   = unpriv_q;

  // R9: a stalled request holds every output
  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_wdata)
      && $stable(out_wb_value) && $stable(out_wb_en) && $stable(out_lanes)
      && $stable(out_unpriv) && $stable(out_load) && $stable(out_byte)));

  // R5: an unprivileged (post-indexed) access always writes the base back
  a_r5_unpriv_implies_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unpriv) |-> out_wb_en);

  // R6: a word access enables every lane
  a_r6_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_byte) |-> (&out_lanes));

  // R7: loads carry no store data
  a_r7_load_no_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_load) |-> (out_wdata == '0));

endmodule

// File: tb/test_ldst_agen.sv
module test_ldst_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_use_reg, in_carry;
  logic [4:0]  in_mode, in_shamt;
  logic [31:0] in_base, in_data, in_rm;
  logic [11:0] in_imm;
  logic [1:0]  in_shtype;
  logic        out_valid, out_ready, out_load, out_byte, out_unpriv, out_wb_en;
  logic [31:0] out_addr, out_wdata, out_wb_value;
  logic [3:0]  out_lanes;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Expected values of the last request driven
  logic [31:0] e_addr, e_wdata, e_wbv;
  logic [3:0]  e_lanes;
  logic        e_load, e_byte, e_unpriv, e_wb;

  ldst_agen i_ldst_agen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base(in_base), .in_data(in_data), .in_use_reg(in_use_reg),
    .in_imm(in_imm), .in_rm(in_rm), .in_shamt(in_shamt), .in_shtype(in_shtype),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_load(out_load), .out_byte(out_byte),
    .out_lanes(out_lanes), .out_wdata(out_wdata), .out_unpriv(out_unpriv),
    .out_wb_en(out_wb_en), .out_wb_value(out_wb_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bit-serial shift model (R8)
  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [4:0] amt,
                                            logic [1:0] kind, logic c);
    logic [31:0] r = v;
    int n = (amt == 0) ? 32 : int'(amt);
    case (kind)
      2'b00: for (int i = 0; i < int'(amt); i++) r = {r[30:0], 1'b0};
      2'b01: for (int i = 0; i < n; i++) r = {1'b0, r[31:1]};
      2'b10: for (int i = 0; i < n; i++) r = {r[31], r[31:1]};
      default:
        if (amt == 0) r = {c, r[31:1]};
        else for (int i = 0; i < int'(amt); i++) r = {r[0], r[31:1]};
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] mode, logic [31:0] base, logic [31:0] data,
                       logic use_reg, logic [11:0] imm, logic [31:0] rm,
                       logic [4:0] shamt, logic [1:0] shtype, logic c);
    logic [31:0] off, comb;
    in_valid = 1'b1; in_mode = mode; in_base = base; in_data = data;
    in_use_reg = use_reg; in_imm = imm; in_rm = rm; in_shamt = shamt;
    in_shtype = shtype; in_carry = c;
    off      = use_reg ? ref_shift(rm, shamt, shtype, c) : {20'd0, imm};
    comb     = mode[3] ? base + off : base - off;
    e_addr   = mode[4] ? comb : base;
    e_wbv    = comb;
    e_wb     = !mode[4] || mode[1];
    e_unpriv = !mode[4] && !mode[1];
    e_byte   = mode[2];
    e_load   = mode[0];
    e_lanes  = mode[2] ? (4'b0001 << e_addr[1:0]) : 4'hF;
    if (mode[0])      e_wdata = 32'd0;
    else if (mode[2]) e_wdata = {24'd0, data[7:0]} << (8 * e_addr[1:0]);
    else              e_wdata = data;
  endtask

  task automatic check_outputs(string ctx);
    check({ctx, " R9 valid"},        {31'd0, out_valid},  32'd1);
    check({ctx, " R3 addr"},         out_addr,            e_addr);
    check({ctx, " R4 wb_en"},        {31'd0, out_wb_en},  {31'd0, e_wb});
    if (e_wb) check({ctx, " R2/R4 wb_value"}, out_wb_value, e_wbv);
    check({ctx, " R5 unpriv"},       {31'd0, out_unpriv}, {31'd0, e_unpriv});
    check({ctx, " R6 byte"},         {31'd0, out_byte},   {31'd0, e_byte});
    check({ctx, " R6 lanes"},        {28'd0, out_lanes},  {28'd0, e_lanes});
    check({ctx, " R7 load"},         {31'd0, out_load},   {31'd0, e_load});
    check({ctx, " R7 wdata"},        out_wdata,           e_wdata);
  endtask

  // Drive at a falling edge; the result is registered at the next rising edge
  task automatic run_one(string ctx, logic [4:0] mode, logic [31:0] base, logic [31:0] data,
                         logic use_reg, logic [11:0] imm, logic [31:0] rm,
                         logic [4:0] shamt, logic [1:0] shtype, logic c);
    out_ready = 1'b1;
    drive(mode, base, data, use_reg, imm, rm, shamt, shtype, c);
    @(negedge clk);
    check_outputs(ctx);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'h5EED_0A17);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_mode = '0; in_base = '0; in_data = '0; in_use_reg = 1'b0; in_imm = '0;
    in_rm = '0; in_shamt = '0; in_shtype = '0; in_carry = 1'b0;
    #(CLK_PERIOD * 3 + CLK_PERIOD/4);
    // R10: reset state
    check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset wb_en",     {31'd0, out_wb_en}, 32'd0);
    check("R9 reset in_ready",   {31'd0, in_ready},  32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every mode value, immediate offset
    for (int m = 0; m < 32; m++)
      run_one("R1 mode sweep", 5'(m), 32'h0000_1002, 32'hA1B2_C3D4, 1'b0, 12'h0F5,
              32'd0, 5'd0, 2'b00, 1'b0);

    // R1: every mode value, register offset
    for (int m = 0; m < 32; m++)
      run_one("R1 reg sweep", 5'(m), 32'h8000_0010, 32'h1234_5678, 1'b1, 12'h0,
              32'hF000_000F, 5'd4, 2'(m % 4), 1'b1);

    // R8: amount zero for each shift kind, both carry values
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++)
        run_one("R8 zero amount", 5'b11000, 32'h0000_4000, 32'h0, 1'b1, 12'h0,
                32'h8000_0003, 5'd0, 2'(k), 1'(c));

    // R8: full-range amount
    run_one("R8 ror 31", 5'b11001, 32'h0, 32'h0, 1'b1, 12'h0, 32'h0000_0003, 5'd31, 2'b11, 1'b0);

    // R6/R7: byte store on each lane
    for (int l = 0; l < 4; l++)
      run_one("R6 R7 byte lane", 5'b11100, 32'h0000_2000 + 32'(l), 32'hDEAD_BE5A, 1'b0,
              12'h0, 32'h0, 5'd0, 2'b00, 1'b0);

    // R2: subtraction wraps below zero; max immediate
    run_one("R2 wrap", 5'b10001, 32'h0000_0002, 32'h0, 1'b0, 12'hFFF, 32'h0, 5'd0, 2'b00, 1'b0);
    run_one("R2 wrap add", 5'b11010, 32'hFFFF_FFFF, 32'h0, 1'b0, 12'h001, 32'h0, 5'd0, 2'b00, 1'b0);

    // R9: stall holds outputs, in_ready drops
    out_ready = 1'b0;
    #1;
    check("R9 in_ready stalled", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_mode = 5'b01111; in_base = 32'h5555_5555; in_imm = 12'h123;
    @(negedge clk);
    check_outputs("R9 hold");
    out_ready = 1'b1;
    drive(5'b01111, 32'h5555_5555, 32'h7777_7777, 1'b0, 12'h123, 32'h0, 5'd0, 2'b00, 1'b0);
    @(negedge clk);
    check_outputs("R9 after stall");

    // R9: no request offered -> valid drops
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 idle drops valid", {31'd0, out_valid}, 32'd0);

    // Random vectors
    for (int i = 0; i < 400; i++)
      run_one("R1-random R2 R3", 5'($urandom), $urandom, $urandom, 1'($urandom),
              12'($urandom), $urandom, 5'($urandom), 2'($urandom), 1'($urandom));

    // R10: reset mid-stream clears valid and writeback enable
    run_one("R10 pre", 5'b00000, 32'h10, 32'h0, 1'b0, 12'h4, 32'h0, 5'd0, 2'b00, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R10 async valid", {31'd0, out_valid}, 32'd0);
    check("R10 async wb_en", {31'd0, out_wb_en}, 32'd0);

    if (seed_sink == 32'hFFFF_FFFF) n_vec = n_vec + 0;
    finish_run();
  end

endmodule